// File: doc/BRIEF.md
# Cascaded Two-Stage Watchdog Timer

This block guards a processor against a runaway program. Two 8-bit down-counters are chained into one 16-bit timeout counter. The low stage steps on a clock-enable tick at one sixteenth of the input clock. The high stage steps either on each wrap of the low stage (cascaded mode) or directly on the same tick (direct mode). When the high stage wraps from zero, the block emits a one-cycle internal reset request.

Software restarts the count by writing a single control register. The write reloads both stages to all ones and stores only the source-select bit. A read of the register returns the select bit and the top six bits of the high stage, which gives a coarse view of how much time is left. A static strap disables the watchdog. A second strap decides whether a stop instruction resets the chip or enters stop mode. Power-mode inputs halt the counter in stop mode. The counter keeps running in wait mode and during oscillator settling.

With a 4 MHz input clock the tick period is 4 µs. The timeout is therefore 65,536 ticks (262.144 ms) in cascaded mode and 256 ticks (1.024 ms) in direct mode.

Top module: `wdog_cascade`

## Requirements
- R1: After reset the register reads 0x3F, and `rst_req` and `stop_enter` are low.
- R2: A read returns the source-select bit in bit 7, zero in bit 6, and high-stage bits 7:2 in bits 5:0.
- R3: With select = 0, the low stage steps on every counted tick. The high stage steps on every wrap of the low stage. `rst_req` is high for one cycle, in the cycle after the 65,536th counted tick since the last reload. Both stages then hold 0xFF and the select bit is kept.
- R4: With select = 1, the high stage steps on every counted tick. `rst_req` pulses after the 256th tick. A cycle with `tick16` low leaves the read value unchanged.
- R5: A register write reloads both stages to 0xFF and stores write bit 7 as the select bit. Write bits 6:0 have no other effect.
- R6: A write in the same cycle as the final timeout tick takes priority. The counter reloads and no `rst_req` is issued.
- R7: While `cfg_wdt_off` is 1, the counter does not move and no timeout `rst_req` occurs.
- R8: After reset, ticks are not counted until `osc_settling` has been seen low.
- R9: The counter holds while `mode_stop` is 1 and `mode_wait` is 0. It runs in wait mode, and it runs during `osc_settling` after leaving stop mode.
- R10: A `stop_exec` strobe gives a one-cycle `rst_req` in the next cycle when `cfg_stop_halts` is 0. When `cfg_stop_halts` is 1, it gives a one-cycle `stop_enter` instead, with no `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdt_off | input | 1 | Static strap; 1 disables the watchdog |
| cfg_stop_halts | input | 1 | Static strap; 1 makes a stop instruction enter stop mode, 0 makes it reset |
| stop_exec | input | 1 | One-cycle strobe: stop instruction executed |
| mode_wait | input | 1 | Wait mode active |
| mode_stop | input | 1 | Stop mode active |
| osc_settling | input | 1 | Oscillation stabilization interval in progress |
| tick16 | input | 1 | Clock enable at input clock / 16 |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| rst_req | output | 1 | One-cycle internal reset request |
| stop_enter | output | 1 | One-cycle request to enter stop mode |

## Verification
Suppose the low stage slips by a single count, or a wrap carries into the high stage a tick early or late. The read value's six high-stage bits then differ from the arithmetic expectation within 4 ticks in direct mode, or 1,024 ticks in cascaded mode. The `rst_req` pulse also lands one cycle off the 65,536th or 256th tick. A lost select bit or a missed reload shows on the very next read. A wrong run qualification, such as counting while stopped, disabled or before the first settling period ends, makes the read value move when it must stay still.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned SEL_BIT = 7;
    localparam int unsigned RD_BITS = 6;

    typedef struct packed {
        logic started;
        logic sel;
    } wdog_cfg_t;

    typedef struct packed {
        logic rst_req;
        logic stop_enter;
    } wdog_out_t;

endpackage

// File: rtl/wdog_stage.sv
module wdog_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    output logic [W-1:0] value,
    output logic         uf
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        uf   = en && !load && (st_q.cnt == '0);
        if (load) begin
            st_d.cnt = '1;
        end else if (en) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;

endmodule

// File: rtl/wdog_gate.sv
module wdog_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wdt_off,
    input  logic mode_wait,
    input  logic mode_stop,
    input  logic osc_settling,
    input  logic tick16,
    output logic cnt_en
);

    typedef struct packed {
        logic started;
    } gate_t;

    gate_t g_d, g_q;
    logic  started_now;
    logic  halted;

    always_comb begin
        g_d         = g_q;
        started_now = g_q.started || !osc_settling;
        g_d.started = started_now;
        halted      = mode_stop && !mode_wait;
        cnt_en      = tick16 && !cfg_wdt_off && started_now && !halted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.started <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [W-1:0]     high_val,
    output logic             sel,
    output logic [REG_W-1:0] reg_rdata
);

    localparam int unsigned GAP = SEL_BIT - RD_BITS;

    typedef struct packed {
        logic sel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            r_d.sel = reg_wdata[SEL_BIT];
        end
        reg_rdata = {r_q.sel, {GAP{1'b0}}, high_val[W-1 -: RD_BITS]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sel <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel = r_q.sel;

endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
    import wdog_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned NSTAGE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wdt_off,
    input  logic             cfg_stop_halts,
    input  logic             stop_exec,
    input  logic             mode_wait,
    input  logic             mode_stop,
    input  logic             osc_settling,
    input  logic             tick16,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             rst_req,
    output logic             stop_enter
);

    localparam int unsigned TOP = NSTAGE - 1;

    logic                    cnt_en;
    logic                    sel;
    logic [NSTAGE-1:0]       stage_en;
    logic [NSTAGE-1:0]       stage_uf;
    logic [NSTAGE-1:0][W-1:0] stage_val;
    logic                    spare_unused;
    logic                    timeout;

    wdog_out_t o_d, o_q;

    wdog_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wdt_off  (cfg_wdt_off),
        .mode_wait    (mode_wait),
        .mode_stop    (mode_stop),
        .osc_settling (osc_settling),
        .tick16       (tick16),
        .cnt_en       (cnt_en)
    );

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_en[i] = cnt_en;
        end else if (i == TOP) begin : g_last
            // the last stage may bypass the chain and take the tick itself
            assign stage_en[i] = sel ? cnt_en : stage_uf[i-1];
        end else begin : g_mid
            assign stage_en[i] = stage_uf[i-1];
        end

        wdog_stage #(.W(W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (stage_en[i]),
            .load  (reg_wr),
            .value (stage_val[i]),
            .uf    (stage_uf[i])
        );
    end

    wdog_regif #(.W(W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .high_val  (stage_val[TOP]),
        .sel       (sel),
        .reg_rdata (reg_rdata)
    );

    assign spare_unused = ^{stage_val, reg_wdata};

    always_comb begin
        o_d            = o_q;
        timeout        = stage_uf[TOP] && !reg_wr;
        o_d.rst_req    = timeout || (stop_exec && !cfg_stop_halts);
        o_d.stop_enter = stop_exec && cfg_stop_halts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rst_req    = o_q.rst_req;
    assign stop_enter = o_q.stop_enter;

endmodule

// File: rtl/wdog_cascade_chk.sv
module wdog_cascade_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wdt_off,
    input logic       cfg_stop_halts,
    input logic       stop_exec,
    input logic       mode_wait,
    input logic       mode_stop,
    input logic       osc_settling,
    input logic       tick16,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       rst_req,
    input logic       stop_enter
);

    assert_bit6_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[6] == 1'b0));

    assert_reload_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (&reg_rdata[5:0]));

    assert_sel_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[7] == $past(reg_wdata[7])));

    assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !stop_exec) |=> !rst_req);

    assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !reg_wr) |=> $stable(reg_rdata));

    assert_off_no_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wdt_off && !stop_exec) |=> !rst_req);

    assert_stop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stop && !mode_wait && !reg_wr) |=> $stable(reg_rdata));

    assert_stop_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_exec && !cfg_stop_halts) |=> (rst_req && !stop_enter));

    assert_stop_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_exec && cfg_stop_halts) |=> stop_enter);

    assert_settle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_settling && !reg_wr && $rose(rst_n)) |=> $stable(reg_rdata));

endmodule

bind wdog_cascade wdog_cascade_chk u_chk (.*);

// File: tb/wdog_cascade_test.sv
module wdog_cascade_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wdt_off = 1'b0;
    logic       cfg_stop_halts = 1'b0;
    logic       stop_exec = 1'b0;
    logic       mode_wait = 1'b0;
    logic       mode_stop = 1'b0;
    logic       osc_settling = 1'b1;
    logic       tick16 = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rst_req;
    logic       stop_enter;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    wdog_cascade uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wdt_off    (cfg_wdt_off),
        .cfg_stop_halts (cfg_stop_halts),
        .stop_exec      (stop_exec),
        .mode_wait      (mode_wait),
        .mode_stop      (mode_stop),
        .osc_settling   (osc_settling),
        .tick16         (tick16),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .rst_req        (rst_req),
        .stop_enter     (stop_enter)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tk, input logic wr, input logic [7:0] wd, input logic sx);
        @(negedge clk);
        tick16    = tk;
        reg_wr    = wr;
        reg_wdata = wd;
        stop_exec = sx;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick16 = 1'b0; reg_wr = 1'b0; stop_exec = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] rd_of(input logic s, input logic [7:0] high);
        return {s, 1'b0, high[7:2]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL all: watchdog actual 200000 cycles expected earlier finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1: reset state
        chk(reg_rdata, 8'h3F, "R1 read");
        chk({7'd0, rst_req}, 8'd0, "R1 rst_req");
        chk({7'd0, stop_enter}, 8'd0, "R1 stop_enter");

        // R8: ticks ignored while still in first settling period
        cyc(1'b0, 1'b1, 8'h80, 1'b0);
        chk(reg_rdata, 8'hBF, "R8 select set");
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            chk(reg_rdata, 8'hBF, "R8 no count before settle");
        end
        osc_settling = 1'b0;

        // R4 and R2: direct mode sweep, ticks on alternate cycles
        cyc(1'b0, 1'b1, 8'h80, 1'b0);
        for (int t = 1; t <= 256; t++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            chk(reg_rdata, rd_of(1'b1, 8'(255 - t)), "R4 R2 direct read");
            chk({7'd0, rst_req}, {7'd0, t == 256}, "R4 direct timeout");
            cyc(1'b0, 1'b0, 8'h00, 1'b0);
            chk(reg_rdata, rd_of(1'b1, 8'(255 - t)), "R4 idle hold");
            chk({7'd0, rst_req}, 8'd0, "R4 pulse width");
        end

        // R5: write reloads and keeps only bit 7
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0);
        chk(reg_rdata, rd_of(1'b1, 8'hF3), "R5 before write");
        cyc(1'b0, 1'b1, 8'h7F, 1'b0);
        chk(reg_rdata, 8'h3F, "R5 write 7F");
        cyc(1'b0, 1'b1, 8'hC0, 1'b0);
        chk(reg_rdata, 8'hBF, "R5 write C0");

        // R6: write collides with final tick
        for (int i = 0; i < 255; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0);
        chk(reg_rdata, rd_of(1'b1, 8'h00), "R6 at zero");
        cyc(1'b1, 1'b1, 8'h80, 1'b0);
        chk({7'd0, rst_req}, 8'd0, "R6 no reset");
        chk(reg_rdata, 8'hBF, "R6 reload");

        // R3 and R9 (wait mode): full cascaded sweep
        mode_wait = 1'b1;
        cyc(1'b0, 1'b1, 8'h00, 1'b0);
        for (int t = 1; t <= 65536; t++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            if (t < 65536)
                chk(reg_rdata, rd_of(1'b0, 8'(255 - (t >> 8))), "R3 cascaded read");
            else
                chk(reg_rdata, 8'h3F, "R3 reload after timeout");
            chk({7'd0, rst_req}, {7'd0, t == 65536}, "R3 timeout pulse");
        end
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        chk({7'd0, rst_req}, 8'd0, "R3 single cycle");
        mode_wait = 1'b0;

        // R9: stop halts, settling after stop runs
        cyc(1'b0, 1'b1, 8'h80, 1'b0);
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0);
        chk(reg_rdata, rd_of(1'b1, 8'hF7), "R9 before stop");
        mode_stop = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            chk(reg_rdata, rd_of(1'b1, 8'hF7), "R9 stop holds");
        end
        mode_stop = 1'b0;
        osc_settling = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0);
        chk(reg_rdata, rd_of(1'b1, 8'hF3), "R9 runs while settling");
        osc_settling = 1'b0;

        // R7: disabled watchdog
        cfg_wdt_off = 1'b1;
        do_reset();
        osc_settling = 1'b0;
        cyc(1'b0, 1'b1, 8'h80, 1'b0);
        for (int i = 0; i < 300; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            chk(reg_rdata, 8'hBF, "R7 frozen");
            chk({7'd0, rst_req}, 8'd0, "R7 no timeout");
        end
        cfg_wdt_off = 1'b0;

        // R10: stop instruction, reset flavour
        cfg_stop_halts = 1'b0;
        do_reset();
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk({6'd0, rst_req, stop_enter}, 8'h02, "R10 stop resets");
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        chk({6'd0, rst_req, stop_enter}, 8'h00, "R10 reset pulse ends");

        // R10: stop instruction, stop-mode flavour
        cfg_stop_halts = 1'b1;
        do_reset();
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk({6'd0, rst_req, stop_enter}, 8'h01, "R10 stop enters");
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        chk({6'd0, rst_req, stop_enter}, 8'h00, "R10 enter pulse ends");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule